// File: doc/BRIEF.md
# Carrier Interrupt Requester with Rotating Priority

This block sits on a mezzanine carrier and merges the interrupt requests of several plug-in modules onto one backplane interrupt line. Each module has two active-low request lines. The block synchronizes them and qualifies each one with its own enable bit. When any qualified request is pending and interrupts are globally enabled, the block pulls down the backplane request line of the level that software programmed.

When the host runs an acknowledge cycle, the block checks the level presented on the address lines against its programmed level. It takes part only once the daisy-chained acknowledge has reached it. On a match with work pending, it consumes the acknowledge and picks one request by rotating priority, with the source serviced most recently ranked last. It strobes the select line of the owning module, drives the local address bit that names request line 0 or 1, and returns the module's vector to the host as one byte or one word. In every other case, the acknowledge continues down the chain.

Software sets up the block through a small write port with four registers and can read them back. Writing ones to the clear register disarms a request until its module releases the line.

Top module: `carrier_irq_top`

## Requirements
- R1: After reset, every bit of `irq_n` and `mod_sel_n` is high, `iack_out_n` is high, and the control, level and enable registers read back 0.
- R2: With the global enable on (bit 3 of the control register, address 0), a programmed level L from 1 to 7 (address 1, bits 2:0) and at least one pending request, `irq_n[L]` is low and every other `irq_n` bit is high. A change on `mod_req_n` reaches `irq_n` within four clock cycles.
- R3: With the global enable off, all `irq_n` bits stay high, and a matching acknowledge is passed on (`iack_out_n` low, no select).
- R4: A request line whose enable bit (address 2, bit i for source i) is 0 is never pending and never raises `irq_n`.
- R5: Writing 1 to bit i of the clear register (address 3) removes source i from pending, and `irq_n` goes high one to two cycles later. The source stays cleared while its line is held low and becomes pending again after the line is released and asserted again. Address 3 reads back the pending set.
- R6: On an acknowledge whose `ack_level` equals the programmed level while a request is pending, the winner's module select `mod_sel_n[i/2]` goes low and `mod_a1` is set to bit 0 of the source number (0 for request line 0, 1 for request line 1). `iack_out_n` stays high for the whole cycle. The response appears the first clock after `iack_in_n` is sampled low.
- R7: On an acknowledge with a different level, or with nothing pending, `iack_out_n` goes low the clock after `iack_in_n` is sampled low. No select is driven, and `iack_out_n` returns high once `iack_in_n` is released.
- R8: Among pending sources, the winner is the first one found after the last serviced source, in ascending order with wrap-around. After reset the search starts at source 0.
- R9: The priority pointer changes only when a served acknowledge completes (`iack_in_n` released while a select is active), and it then points at the source just served. Passed acknowledges leave it unchanged.
- R10: While serving, `host_vec_vld` is high. `host_vec` carries `mod_data` in full when the control register's bit 0 (word vector) is set; otherwise it carries `mod_data[7:0]` with the upper byte zero.
- R11: A programmed level of 0 keeps all `irq_n` bits high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 control, 1 level, 2 enable, 3 clear |
| reg_wdata | input | 2*N_MOD | Write data |
| reg_rd_addr | input | 2 | Read address; address 3 returns the pending set |
| reg_rdata | output | 2*N_MOD | Read data (combinational) |
| mod_req_n | input | 2*N_MOD | Module request lines, active low; source i belongs to module i/2 |
| mod_sel_n | output | N_MOD | Per-module acknowledge select strobe, active low |
| mod_a1 | output | 1 | Local address bit selecting request line 0 or 1 |
| mod_data | input | VEC_W | Local data bus carrying the selected module's vector |
| irq_n | output | 7 (7:1) | Backplane interrupt requests by level, active low |
| iack_in_n | input | 1 | Daisy-chained acknowledge in, active low, synchronous to clk |
| ack_level | input | 3 | Level requested by the host during acknowledge |
| iack_out_n | output | 1 | Acknowledge passed down the chain, active low |
| host_vec | output | VEC_W | Vector returned to the host |
| host_vec_vld | output | 1 | High while the block is serving an acknowledge |

## Verification
A vector table covers single requests, two requests at opposite ends of the source range (which shows that the winner follows the pointer rather than a fixed order), requests that are all masked, a level mismatch followed by a match on the same inputs, and a lone enabled source on the second line of a module. With every request held asserted, sixteen acknowledges in a row must visit each source once per round in order, which separates true rotation from fixed or stuck priority. Directed cases cover the global enable off, a programmed level of 0, the clear-and-rearm sequence, and both vector widths against one bus value whose two bytes differ.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;

  localparam int LVL_W        = 3;
  localparam int NUM_LVL      = 7;
  localparam int BYTE_W       = 8;
  localparam int RADDR_W      = 2;

  localparam logic [RADDR_W-1:0] RA_CTRL   = 2'd0;
  localparam logic [RADDR_W-1:0] RA_LEVEL  = 2'd1;
  localparam logic [RADDR_W-1:0] RA_ENABLE = 2'd2;
  localparam logic [RADDR_W-1:0] RA_CLEAR  = 2'd3;

  localparam int CTRL_GIE_BIT  = 3;
  localparam int CTRL_WIDE_BIT = 0;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_SERVE = 2'd1,
    ACK_PASS  = 2'd2
  } ack_state_e;

endpackage

// File: rtl/carrier_irq_sync.sv
module carrier_irq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/carrier_irq_regs.sv
module carrier_irq_regs
  import carrier_irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RADDR_W-1:0] wr_addr,
  input  logic [N_SRC-1:0]   wr_data,
  input  logic [RADDR_W-1:0] rd_addr,
  output logic [N_SRC-1:0]   rd_data,
  input  logic [N_SRC-1:0]   pending,
  output logic               gie,
  output logic               wide,
  output logic [LVL_W-1:0]   level,
  output logic [N_SRC-1:0]   enable,
  output logic [N_SRC-1:0]   clear_hit
);

  logic             gie_q, gie_d;
  logic             wide_q, wide_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [N_SRC-1:0] enable_q, enable_d;
  logic             ctrl_we, level_we, enable_we, clear_we;

  assign ctrl_we   = wr_en && (wr_addr == RA_CTRL);
  assign level_we  = wr_en && (wr_addr == RA_LEVEL);
  assign enable_we = wr_en && (wr_addr == RA_ENABLE);
  assign clear_we  = wr_en && (wr_addr == RA_CLEAR);

  always_comb begin
    gie_d    = gie_q;
    wide_d   = wide_q;
    level_d  = level_q;
    enable_d = enable_q;
    if (ctrl_we) begin
      gie_d  = wr_data[CTRL_GIE_BIT];
      wide_d = wr_data[CTRL_WIDE_BIT];
    end
    if (level_we)  level_d  = wr_data[LVL_W-1:0];
    if (enable_we) enable_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      wide_q   <= 1'b0;
      level_q  <= '0;
      enable_q <= '0;
    end else begin
      gie_q    <= gie_d;
      wide_q   <= wide_d;
      level_q  <= level_d;
      enable_q <= enable_d;
    end
  end

  assign clear_hit = clear_we ? wr_data : '0;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_CTRL: begin
        rd_data[CTRL_GIE_BIT]  = gie_q;
        rd_data[CTRL_WIDE_BIT] = wide_q;
      end
      RA_LEVEL:  rd_data[LVL_W-1:0] = level_q;
      RA_ENABLE: rd_data = enable_q;
      default:   rd_data = pending;
    endcase
  end

  assign gie    = gie_q;
  assign wide   = wide_q;
  assign level  = level_q;
  assign enable = enable_q;

endmodule

// File: rtl/carrier_irq_pend.sv
module carrier_irq_pend #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] enable,
  input  logic [N_SRC-1:0] clear_hit,
  output logic [N_SRC-1:0] pending
);

  logic [N_SRC-1:0] armed_q, armed_d;

  // A cleared source re-arms only once its line is seen released.
  always_comb begin
    armed_d = (armed_q & ~clear_hit) | ~req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= '1;
    else        armed_q <= armed_d;
  end

  assign pending = req & enable & armed_q;

endmodule

// File: rtl/carrier_irq_pick.sv
module carrier_irq_pick #(
  parameter int N_SRC = 8,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pending,
  input  logic [SRC_W-1:0] last,
  output logic             any,
  output logic [SRC_W-1:0] winner
);

  function automatic logic [SRC_W-1:0] wrap_idx(input logic [SRC_W-1:0] base, input int step);
    return SRC_W'((int'(base) + step) % N_SRC);
  endfunction

  always_comb begin
    any    = 1'b0;
    winner = '0;
    for (int k = 1; k <= N_SRC; k++) begin
      if (!any && pending[wrap_idx(last, k)]) begin
        any    = 1'b1;
        winner = wrap_idx(last, k);
      end
    end
  end

endmodule

// File: rtl/carrier_irq_ack.sv
module carrier_irq_ack
  import carrier_irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_in_n,
  input  logic [LVL_W-1:0] ack_level,
  input  logic [LVL_W-1:0] level,
  input  logic             gie,
  input  logic             any_pend,
  input  logic [SRC_W-1:0] winner,
  output ack_state_e       state,
  output logic [SRC_W-1:0] sel_src,
  output logic [SRC_W-1:0] last_src,
  output logic             iack_out_n
);

  ack_state_e       state_q, state_d;
  logic [SRC_W-1:0] sel_q, sel_d;
  logic [SRC_W-1:0] last_q, last_d;
  logic             pass_q, pass_d;
  logic             claim;

  assign claim = gie && any_pend && (level != '0) && (ack_level == level);

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    last_d  = last_q;
    unique case (state_q)
      ACK_IDLE: begin
        if (!iack_in_n) begin
          if (claim) begin
            state_d = ACK_SERVE;
            sel_d   = winner;
          end else begin
            state_d = ACK_PASS;
          end
        end
      end
      ACK_SERVE: begin
        if (iack_in_n) begin
          state_d = ACK_IDLE;
          last_d  = sel_q;
        end
      end
      default: begin
        if (iack_in_n) state_d = ACK_IDLE;
      end
    endcase
    pass_d = (state_d == ACK_PASS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      sel_q   <= '0;
      last_q  <= SRC_W'(N_SRC - 1);
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      last_q  <= last_d;
      pass_q  <= pass_d;
    end
  end

  assign state      = state_q;
  assign sel_src    = sel_q;
  assign last_src   = last_q;
  assign iack_out_n = !pass_q;

endmodule

// File: rtl/carrier_irq_top.sv
module carrier_irq_top
  import carrier_irq_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int VEC_W = 16,
  localparam int N_SRC = 2 * N_MOD,
  localparam int SRC_W = $clog2(N_SRC),
  localparam int MOD_W = SRC_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [N_SRC-1:0]   reg_wdata,
  input  logic [RADDR_W-1:0] reg_rd_addr,
  output logic [N_SRC-1:0]   reg_rdata,
  input  logic [N_SRC-1:0]   mod_req_n,
  output logic [N_MOD-1:0]   mod_sel_n,
  output logic               mod_a1,
  input  logic [VEC_W-1:0]   mod_data,
  output logic [NUM_LVL:1]   irq_n,
  input  logic               iack_in_n,
  input  logic [LVL_W-1:0]   ack_level,
  output logic               iack_out_n,
  output logic [VEC_W-1:0]   host_vec,
  output logic               host_vec_vld
);

  logic             rst_sync_n;
  logic [N_SRC-1:0] req_sync;
  logic [N_SRC-1:0] pending, enable, clear_hit;
  logic             gie, wide, any_pend, serving;
  logic [LVL_W-1:0] level;
  logic [SRC_W-1:0] winner, sel_src, last_src;
  ack_state_e       ack_state;
  logic [NUM_LVL:1] irq_q, irq_d;

  carrier_irq_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  carrier_irq_sync #(.W(N_SRC), .RST_VAL('0)) u_req_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(~mod_req_n), .q(req_sync)
  );

  carrier_irq_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .rd_addr(reg_rd_addr), .rd_data(reg_rdata), .pending(pending),
    .gie(gie), .wide(wide), .level(level), .enable(enable), .clear_hit(clear_hit)
  );

  carrier_irq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .req(req_sync), .enable(enable),
    .clear_hit(clear_hit), .pending(pending)
  );

  carrier_irq_pick #(.N_SRC(N_SRC)) u_pick (
    .pending(pending), .last(last_src), .any(any_pend), .winner(winner)
  );

  carrier_irq_ack #(.N_SRC(N_SRC)) u_ack (
    .clk(clk), .rst_n(rst_sync_n), .iack_in_n(iack_in_n), .ack_level(ack_level),
    .level(level), .gie(gie), .any_pend(any_pend), .winner(winner),
    .state(ack_state), .sel_src(sel_src), .last_src(last_src), .iack_out_n(iack_out_n)
  );

  assign serving = (ack_state == ACK_SERVE);

  // Backplane request per level.
  for (genvar lv = 1; lv <= NUM_LVL; lv++) begin : g_lvl
    assign irq_d[lv] = !(gie && any_pend && (level == LVL_W'(lv)));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= '1;
    else             irq_q <= irq_d;
  end

  assign irq_n = irq_q;

  // Per-module select strobe.
  for (genvar m = 0; m < N_MOD; m++) begin : g_sel
    assign mod_sel_n[m] = !(serving && (sel_src[SRC_W-1:1] == MOD_W'(m)));
  end

  assign mod_a1       = serving && sel_src[0];
  assign host_vec_vld = serving;

  always_comb begin
    host_vec = '0;
    if (serving) begin
      if (wide) host_vec = mod_data;
      else      host_vec[BYTE_W-1:0] = mod_data[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/carrier_irq_chk.sv
module carrier_irq_chk #(
  parameter int N_MOD = 4,
  localparam int N_SRC = 2 * N_MOD,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic [7:1]       irq_n,
  input logic [N_MOD-1:0] mod_sel_n,
  input logic             iack_in_n,
  input logic             iack_out_n,
  input logic [SRC_W-1:0] last_src
);

  AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n) <= 1); // R2

  AST_GIE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> (&irq_n)); // R3

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mod_sel_n)); // R6

  AST_SERVE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mod_sel_n) |-> iack_out_n); // R6

  AST_PASS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_out_n |-> (&mod_sel_n)); // R7

  AST_PTR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_src) |-> $past(iack_in_n && !(&mod_sel_n))); // R9

endmodule

bind carrier_irq_top carrier_irq_chk #(.N_MOD(N_MOD)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .gie(gie), .irq_n(irq_n),
  .mod_sel_n(mod_sel_n), .iack_in_n(iack_in_n), .iack_out_n(iack_out_n),
  .last_src(last_src)
);

// File: tb/carrier_irq_top_tb.sv
module carrier_irq_top_tb;

  localparam int N_MOD = 4;
  localparam int N_SRC = 8;
  localparam int VEC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             reg_wr_en;
  logic [1:0]       reg_addr, reg_rd_addr;
  logic [N_SRC-1:0] reg_wdata, reg_rdata;
  logic [N_SRC-1:0] mod_req_n;
  logic [N_MOD-1:0] mod_sel_n;
  logic             mod_a1;
  logic [VEC_W-1:0] mod_data;
  logic [7:1]       irq_n;
  logic             iack_in_n;
  logic [2:0]       ack_level;
  logic             iack_out_n;
  logic [VEC_W-1:0] host_vec;
  logic             host_vec_vld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  carrier_irq_top #(.N_MOD(N_MOD), .VEC_W(VEC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .mod_req_n(mod_req_n), .mod_sel_n(mod_sel_n), .mod_a1(mod_a1),
    .mod_data(mod_data), .irq_n(irq_n), .iack_in_n(iack_in_n),
    .ack_level(ack_level), .iack_out_n(iack_out_n), .host_vec(host_vec),
    .host_vec_vld(host_vec_vld)
  );

  // {enable, request, level, ack level, expect serve, expect source}
  localparam logic [25:0] TBL [0:7] = '{
    {8'hFF, 8'h01, 3'd3, 3'd3, 1'b1, 3'd0},
    {8'hFF, 8'h81, 3'd3, 3'd3, 1'b1, 3'd7},
    {8'hFF, 8'h81, 3'd3, 3'd3, 1'b1, 3'd0},
    {8'h0F, 8'hF0, 3'd3, 3'd3, 1'b0, 3'd0},
    {8'hFF, 8'h0C, 3'd5, 3'd4, 1'b0, 3'd0},
    {8'hFF, 8'h0C, 3'd5, 3'd5, 1'b1, 3'd2},
    {8'hFF, 8'h0C, 3'd5, 3'd5, 1'b1, 3'd3},
    {8'h20, 8'h2F, 3'd7, 3'd7, 1'b1, 3'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:1] exp_irq(input logic act, input logic [2:0] lvl);
    if (act && lvl != 3'd0) return ~(7'b1 << (lvl - 3'd1));
    return 7'h7F;
  endfunction

  // Starts an acknowledge, samples the response one clock later, then releases.
  task automatic ack(input logic [2:0] lvl, output logic [3:0] sel, output logic a1,
                     output logic out_n, output logic [15:0] vec, output logic vld);
    @(negedge clk);
    iack_in_n = 1'b0; ack_level = lvl;
    @(negedge clk);
    sel = mod_sel_n; a1 = mod_a1; out_n = iack_out_n; vec = host_vec; vld = host_vec_vld;
    iack_in_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_serve(input string req, input logic [2:0] src, input logic [3:0] sel,
                             input logic a1, input logic out_n);
    logic [3:0] es;
    es = ~(4'b1 << src[2:1]);
    chk(sel == es, req, sel, es);
    chk(a1 == src[0], req, a1, src[0]);
    chk(out_n == 1'b1, req, out_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [3:0]  sel;
    logic        a1, out_n, vld;
    logic [15:0] vec;

    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; reg_rd_addr = '0;
    mod_req_n = '1; mod_data = 16'hA5C3; iack_in_n = 1'b1; ack_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(irq_n == 7'h7F, "R1 irq", irq_n, 7'h7F);
    chk(mod_sel_n == 4'hF, "R1 sel", mod_sel_n, 4'hF);
    chk(iack_out_n == 1'b1, "R1 iack_out", iack_out_n, 1);
    rd(2'd0, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 level", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R1 enable", d, 0);

    // Table walk: R2 R4 R6 R7 R8 R9
    wr(2'd0, 8'h08);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] en, rq;
      logic [2:0] lv, al, src;
      logic       hit;
      {en, rq, lv, al, hit, src} = TBL[i];
      wr(2'd2, en);
      wr(2'd1, {5'd0, lv});
      mod_req_n = ~rq;
      settle();
      chk(irq_n == exp_irq(|(en & rq), lv), "R2 R4 irq level", irq_n, exp_irq(|(en & rq), lv));
      ack(al, sel, a1, out_n, vec, vld);
      if (hit) check_serve("R6 R8 R9 winner", src, sel, a1, out_n);
      else begin
        chk(out_n == 1'b0, "R7 pass", out_n, 0);
        chk(sel == 4'hF, "R7 no select", sel, 4'hF);
      end
      chk(iack_out_n == 1'b1, "R7 released", iack_out_n, 1);
      mod_req_n = '1;
      settle();
    end

    // R8: fairness with every request held; pointer last at source 5
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'd2);
    mod_req_n = '0;
    settle();
    for (int i = 0; i < 16; i++) begin
      logic [2:0] es;
      es = 3'((6 + i) % 8);
      ack(3'd2, sel, a1, out_n, vec, vld);
      check_serve("R8 rotation", es, sel, a1, out_n);
    end

    // R10: vector width, source 0 served next after 5 -> 6; drive only source 0
    mod_req_n = 8'hFE;
    settle();
    ack(3'd2, sel, a1, out_n, vec, vld);
    chk(vld == 1'b1, "R10 valid", vld, 1);
    chk(vec == 16'h00C3, "R10 byte vector", vec, 16'h00C3);
    wr(2'd0, 8'h09);
    ack(3'd2, sel, a1, out_n, vec, vld);
    chk(vec == 16'hA5C3, "R10 word vector", vec, 16'hA5C3);
    chk(host_vec_vld == 1'b0, "R10 valid drops", host_vec_vld, 0);

    // R11: level zero
    wr(2'd1, 8'd0);
    settle();
    chk(irq_n == 7'h7F, "R11 level zero", irq_n, 7'h7F);

    // R3: global enable off
    wr(2'd1, 8'd4);
    wr(2'd0, 8'h00);
    settle();
    chk(irq_n == 7'h7F, "R3 irq quiet", irq_n, 7'h7F);
    ack(3'd4, sel, a1, out_n, vec, vld);
    chk(out_n == 1'b0, "R3 ack passed", out_n, 0);
    chk(sel == 4'hF, "R3 no select", sel, 4'hF);

    // R5: clear disarms until the line is released
    wr(2'd0, 8'h08);
    mod_req_n = 8'hFD;
    settle();
    chk(irq_n == exp_irq(1'b1, 3'd4), "R5 before clear", irq_n, exp_irq(1'b1, 3'd4));
    wr(2'd3, 8'h02);
    @(negedge clk);
    chk(irq_n == 7'h7F, "R5 cleared", irq_n, 7'h7F);
    rd(2'd3, d); chk(d == 8'h00, "R5 pending readback", d, 0);
    settle();
    chk(irq_n == 7'h7F, "R5 stays cleared", irq_n, 7'h7F);
    mod_req_n = '1;
    settle();
    mod_req_n = 8'hFD;
    settle();
    chk(irq_n == exp_irq(1'b1, 3'd4), "R5 rearmed", irq_n, exp_irq(1'b1, 3'd4));
    rd(2'd3, d); chk(d == 8'h02, "R5 pending back", d, 8'h02);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule